// File: doc/BRIEF.md
# Automatic Level Control Gain Stepper

This block steers a 7-bit amplifier gain code from a stream of signed 16-bit audio samples. One code step is worth 0.5 dB, and code 0 means mute. Each valid sample is reduced to its magnitude and sorted into one of three classes: hot (at or above the limiter level), band (the 2 dB window just under the limiter level), or quiet (everything lower). A hot sample cuts the gain by the attack step, with a minimum spacing between cuts. A run of quiet samples raises the gain by the recovery step. A band sample restarts that run.

Software issues fade commands as single-cycle pulses. The block holds a pending fade until the next valid sample that does not cause a limiter cut. The fade then moves the gain by one or two codes, upward toward the reference ceiling or downward toward mute. While a fade is pending, automatic recovery is held off. Every gain change happens on a clock edge where a valid sample is presented, except for reset.

Top module: `alc_gain_stepper`

## Requirements
- R1: A synchronous reset loads `gain` with `ref_code`, clears the recovery run, the limiter spacing counter and any pending fade.
- R2: Sample magnitude is the two's-complement absolute value, so -32768 gives 32768. With `thr_sel`=0 a sample is hot when the magnitude is at least 20675; with `thr_sel`=1 it is hot when the magnitude is at least 26029.
- R3: A limiter cut lowers `gain` by `atk_sel`+1 codes (00→1, 01→2, 10→3, 11→4).
- R4: A limiter cut that would go below 0 leaves `gain` at 0.
- R5: After a cut, further cuts are blocked for the next 2^t−1 valid samples. Here t is `zc_tm` when `zc_mode`=1 and `lim_tm` otherwise. A hot sample that arrives while cuts are blocked leaves `gain` unchanged.
- R6: A band sample restarts the recovery run and leaves `gain` unchanged. The band is [16423, 20675) when `thr_sel`=0 and [20675, 26029) when `thr_sel`=1. A hot sample also restarts the run.
- R7: The recovery run counts consecutive quiet valid samples. When the run reaches `wait_len`, a recovery step adds `rec_sel`+1 codes and the run restarts. A `wait_len` of 0 acts as 1.
- R8: Recovery and fade-in never raise `gain` above `ref_code`. If `gain` is already at or above `ref_code`, they leave it unchanged.
- R9: A pulse on `fade_out_req` or `fade_in_req` becomes pending; `fade_out_req` wins if both are pulsed. The pending fade executes on the next valid sample that does not cause a limiter cut. Its step is 1 code when `fade_sel`=0 and 2 codes when `fade_sel`=1. Fade-out floors at 0 and fade-in stops at the ceiling.
- R10: While a fade is pending, a recovery step that falls due is dropped and the run restarts.
- R11: `gain` holds its value on every edge without `smp_valid` and without reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe |
| smp | input | 16 | Signed audio sample |
| thr_sel | input | 1 | Limiter level select |
| atk_sel | input | 2 | Limiter cut size code |
| rec_sel | input | 2 | Recovery step size code |
| fade_sel | input | 1 | Fade step size code |
| zc_mode | input | 1 | Selects which spacing field applies |
| lim_tm | input | 2 | Cut spacing exponent, `zc_mode`=0 |
| zc_tm | input | 2 | Cut spacing exponent, `zc_mode`=1 |
| wait_len | input | 8 | Quiet samples needed per recovery step |
| ref_code | input | 7 | Gain ceiling and reset value |
| fade_in_req | input | 1 | Fade-in request pulse |
| fade_out_req | input | 1 | Fade-out request pulse |
| gain | output | 7 | Current gain code |

## Verification
Every gain change caused by a sample is due at the clock edge that samples `smp_valid`. The bench therefore drives each sample on a falling edge, lets one rising edge pass, and compares `gain` on the following falling edge. A fade pulse lands in the pending state at its own edge but moves `gain` only on the edge of a later valid sample. The bench's arithmetic model applies the same one-edge delay before it predicts the value. Idle cycles are interleaved with samples so that the hold behaviour is compared on the same falling-edge schedule.

// File: rtl/alc_gain_stepper.sv
module alc_gain_stepper #(
  parameter int GW     = 7,
  parameter int SW     = 16,
  parameter int WW     = 8,
  parameter int TW     = 2,
  parameter int LVL_M2 = 26029,
  parameter int LVL_M4 = 20675,
  parameter int LVL_M6 = 16423
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_valid,
  input  logic signed [SW-1:0] smp,
  input  logic                 thr_sel,
  input  logic [1:0]           atk_sel,
  input  logic [1:0]           rec_sel,
  input  logic                 fade_sel,
  input  logic                 zc_mode,
  input  logic [TW-1:0]        lim_tm,
  input  logic [TW-1:0]        zc_tm,
  input  logic [WW-1:0]        wait_len,
  input  logic [GW-1:0]        ref_code,
  input  logic                 fade_in_req,
  input  logic                 fade_out_req,
  output logic [GW-1:0]        gain
);
  localparam int HW = 2**TW - 1;

  logic [SW-1:0] mag;
  logic [SW-1:0] hi_lvl, lo_lvl;
  logic          hot, band, quiet;
  logic [HW-1:0] hold, hold_load;
  logic [TW-1:0] tsel;
  logic [WW-1:0] wait_cnt, wlen;
  logic          fp_in, fp_out, fpend;
  logic          lim_step, fade_go, wait_hit, rec_go;
  logic [GW-1:0] g_next;
  logic          past_ok;

  function automatic logic [GW-1:0] sub_sat(input logic [GW-1:0] g, input logic [2:0] d);
    return (g > GW'(d)) ? g - GW'(d) : '0;
  endfunction

  function automatic logic [GW-1:0] up_cap(input logic [GW-1:0] g, input logic [2:0] d,
                                           input logic [GW-1:0] r);
    logic [GW:0] s;
    s = {1'b0, g} + (GW+1)'(d);
    if (g >= r)               return g;
    else if (s > {1'b0, r})   return r;
    else                      return s[GW-1:0];
  endfunction

  assign mag    = smp[SW-1] ? SW'(-smp) : SW'(smp);
  assign hi_lvl = thr_sel ? SW'(LVL_M2) : SW'(LVL_M4);
  assign lo_lvl = thr_sel ? SW'(LVL_M4) : SW'(LVL_M6);
  assign hot    = mag >= hi_lvl;
  assign band   = !hot && (mag >= lo_lvl);
  assign quiet  = !hot && !band;

  assign tsel      = zc_mode ? zc_tm : lim_tm;
  assign hold_load = HW'((1 << tsel) - 1);
  assign fpend     = fp_in || fp_out;
  assign wlen      = (wait_len == '0) ? WW'(1) : wait_len;

  assign lim_step = smp_valid && hot && (hold == '0);
  assign fade_go  = smp_valid && !lim_step && fpend;
  assign wait_hit = smp_valid && quiet && ({1'b0, wait_cnt} + 1'b1 >= {1'b0, wlen});
  assign rec_go   = wait_hit && !fpend;

  always_comb begin
    g_next = gain;
    if (lim_step)
      g_next = sub_sat(gain, {1'b0, atk_sel} + 3'd1);
    else if (fade_go)
      g_next = fp_out ? sub_sat(gain, fade_sel ? 3'd2 : 3'd1)
                      : up_cap(gain, fade_sel ? 3'd2 : 3'd1, ref_code);
    else if (rec_go)
      g_next = up_cap(gain, {1'b0, rec_sel} + 3'd1, ref_code);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gain     <= ref_code;
      hold     <= '0;
      wait_cnt <= '0;
      fp_in    <= 1'b0;
      fp_out   <= 1'b0;
      past_ok  <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      gain    <= g_next;
      if (smp_valid) begin
        hold     <= lim_step ? hold_load : ((hold != '0) ? hold - 1'b1 : '0);
        wait_cnt <= (!quiet || wait_hit) ? '0 : wait_cnt + 1'b1;
      end
      if (fade_out_req)     begin fp_out <= 1'b1; fp_in <= 1'b0; end
      else if (fade_in_req) begin fp_out <= 1'b0; fp_in <= 1'b1; end
      else if (fade_go)     begin fp_out <= 1'b0; fp_in <= 1'b0; end
    end
  end

  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (rst)
    past_ok && !smp_valid |=> $stable(gain));

  assert_ceiling_R8: assert property (@(posedge clk) disable iff (rst)
    past_ok && $stable(ref_code) && (gain > $past(gain)) |-> gain <= ref_code);

  assert_cut_down_R3: assert property (@(posedge clk) disable iff (rst)
    past_ok && smp_valid && hot && (hold == '0) |=> (gain < $past(gain)) || ($past(gain) == '0));

  assert_fade_consumed_R9: assert property (@(posedge clk) disable iff (rst)
    past_ok && fade_go && !fade_in_req && !fade_out_req |=> !fp_in && !fp_out);

  assert_pending_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> $onehot0({fp_in, fp_out}));

  assert_blocked_cut_R5: assert property (@(posedge clk) disable iff (rst)
    past_ok && smp_valid && hot && (hold != '0) && !fpend |=> $stable(gain));
endmodule

// File: tb/tb_alc_gain_stepper.sv
module tb_alc_gain_stepper;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, smp_valid, thr_sel, fade_sel, zc_mode, fade_in_req, fade_out_req;
  logic signed [15:0] smp;
  logic [1:0] atk_sel, rec_sel, lim_tm, zc_tm;
  logic [7:0] wait_len;
  logic [6:0] ref_code, gain;

  alc_gain_stepper dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp(smp), .thr_sel(thr_sel),
    .atk_sel(atk_sel), .rec_sel(rec_sel), .fade_sel(fade_sel), .zc_mode(zc_mode),
    .lim_tm(lim_tm), .zc_tm(zc_tm), .wait_len(wait_len), .ref_code(ref_code),
    .fade_in_req(fade_in_req), .fade_out_req(fade_out_req), .gain(gain));

  int tests = 0, fails = 0;
  int m_gain, m_hold, m_wait;
  bit m_fin, m_fout;
  string tag;

  function automatic int cap_up(int g, int d, int r);
    if (g >= r) return g;
    return (g + d > r) ? r : g + d;
  endfunction

  function automatic int floor_dn(int g, int d);
    return (g > d) ? g - d : 0;
  endfunction

  task automatic check(string t, int exp);
    tests++;
    if (gain !== 7'(exp)) begin
      fails++;
      $display("FAIL %s: gain=%0d expected %0d", t, gain, exp);
    end
  endtask

  task automatic model(bit v, int s, bit fi, bit fo);
    int mg, hi, lo, t, wl, ng;
    bit hot, band, cut, fgo, hit;
    mg  = (s < 0) ? -s : s;
    hi  = thr_sel ? 26029 : 20675;
    lo  = thr_sel ? 20675 : 16423;
    hot = mg >= hi;
    band = !hot && mg >= lo;
    t   = zc_mode ? zc_tm : lim_tm;
    wl  = (wait_len == 0) ? 1 : wait_len;
    cut = v && hot && m_hold == 0;
    fgo = v && !cut && (m_fin || m_fout);
    hit = v && !hot && !band && (m_wait + 1 >= wl);
    ng  = m_gain;
    tag = "R11";
    if (cut) begin
      ng  = floor_dn(m_gain, atk_sel + 1);
      tag = (m_gain <= atk_sel + 1) ? "R4" : "R3";
    end else if (fgo) begin
      ng  = m_fout ? floor_dn(m_gain, fade_sel ? 2 : 1)
                   : cap_up(m_gain, fade_sel ? 2 : 1, ref_code);
      tag = "R9";
    end else if (hit && (m_fin || m_fout)) tag = "R10";
    else if (hit) begin
      ng  = cap_up(m_gain, rec_sel + 1, ref_code);
      tag = (m_gain + rec_sel + 1 > ref_code) ? "R8" : "R7";
    end else if (v && hot) tag = "R5";
    else if (v && band) tag = "R6";
    else if (v) tag = "R2";
    if (v) begin
      m_hold = cut ? (1 << t) - 1 : (m_hold > 0 ? m_hold - 1 : 0);
      m_wait = (hot || band || hit) ? 0 : m_wait + 1;
    end
    if (fo) begin m_fout = 1; m_fin = 0; end
    else if (fi) begin m_fout = 0; m_fin = 1; end
    else if (fgo) begin m_fout = 0; m_fin = 0; end
    m_gain = ng;
  endtask

  task automatic step(bit v, int s, bit fi, bit fo);
    smp_valid = v; smp = 16'(s); fade_in_req = fi; fade_out_req = fo;
    model(v, s, fi, fo);
    @(posedge clk);
    @(negedge clk);
    smp_valid = 0; fade_in_req = 0; fade_out_req = 0;
    check(tag, m_gain);
  endtask

  task automatic do_reset();
    rst = 1; smp_valid = 0; fade_in_req = 0; fade_out_req = 0; smp = 0;
    @(posedge clk); @(negedge clk);
    rst = 0;
    m_gain = ref_code; m_hold = 0; m_wait = 0; m_fin = 0; m_fout = 0;
    check("R1", ref_code);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: gain=%0d expected progress", gain);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit [15:0] lf;
    int s;
    rst = 1; smp_valid = 0; smp = 0; fade_in_req = 0; fade_out_req = 0;
    thr_sel = 0; atk_sel = 0; rec_sel = 0; fade_sel = 0; zc_mode = 0;
    lim_tm = 0; zc_tm = 0; wait_len = 2; ref_code = 7'h40;
    @(negedge clk);
    do_reset();

    // R2 / R4 directed: boundary magnitudes, clip to mute
    atk_sel = 3; ref_code = 7'd3; do_reset();
    step(1, 20674, 0, 0); check("R2", 3);
    step(1, -20675, 0, 0); check("R4", 0);
    thr_sel = 1; ref_code = 7'd40; do_reset();
    step(1, 20675, 0, 0); check("R6", 40);
    step(1, -32768, 0, 0); check("R3", 36);

    // R8 directed: recovery at ceiling stays put
    thr_sel = 0; wait_len = 1; do_reset();
    step(1, 5, 0, 0); check("R8", 40);

    lf = 16'hACE1;
    for (int c = 0; c < 512; c++) begin
      thr_sel  = c[0];   atk_sel = c[2:1]; rec_sel = c[4:3];
      fade_sel = c[5];   zc_mode = c[6];   lim_tm  = c[8:7];
      zc_tm    = ~c[8:7]; wait_len = 8'(c % 4);
      ref_code = 7'((c * 37) % 128);
      do_reset();
      for (int k = 0; k < 60; k++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        case (lf[3:0])
          4'd6:  s = 16422;
          4'd7:  s = 16423;
          4'd8:  s = 20674;
          4'd9:  s = 20675;
          4'd10: s = 26028;
          4'd11: s = 26029;
          4'd12: s = 32767;
          4'd13: s = -32768;
          default: s = int'(lf[15:4]) * 3;
        endcase
        if (lf[4] && s != -32768) s = -s;
        step(lf[3:0] != 4'd14, s, lf[15:12] == 4'd0 || lf[15:12] == 4'd2,
             lf[15:12] == 4'd1 || lf[15:12] == 4'd2);
      end
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule